// File: doc/BRIEF.md
# Hash Padding Trailer Detector

This block decides, for each request buffer of an accumulated multi-request hash message, whether the buffer carries the closing padded block and where that padding begins. It keeps a running byte count over all requests of the current message. For every request it fetches the last eight bytes of the buffer, one byte per cycle, through a byte-addressed read port. It reads them as a big-endian bit count and checks that count against the running total. When the count is consistent, it fetches one more byte at the computed padding offset and looks for the 0x80 marker.

A consumer starts a request with a one-cycle start strobe and the request length, serves the read port from the request buffer, and waits for the result pulse. When the result says final, the consumer hashes only the bytes below the reported offset and the block begins a fresh message. A list-end marker seen elsewhere never makes a request final. Only the trailer-and-marker test does. A clear strobe lets the consumer abandon a message and restart the count.

Top module: `pad_trailer_detect`

## Requirements
- R1: After reset the block is idle (busy low), issues no reads, reports no result, and the running total is zero.
- R2: A start strobe is taken only while idle; from the next cycle busy stays high until the result pulse.
- R3: The request length is added to the running total when the request is taken, before any check uses the total.
- R4: The trailer is the buffer's last eight bytes, read at byte addresses L-8 to L-1 (L = request length). The byte at L-8 is the most significant. The claimed message length in bytes is this 64-bit value divided by 8, with the remainder dropped.
- R5: A request whose claimed length exceeds the running total is reported not final.
- R6: The padding size P is the running total minus the claimed length, and the offset is L-P. A request can only be final when 1 <= P <= L, so the offset lies in 0..L-1. Otherwise it is reported not final and no marker read is made.
- R7: A request that passes R5 and R6 is final only if the byte read at the offset equals 0x80.
- R8: Each request yields exactly one result: res_valid_o high for one cycle, with res_final_o and res_off_o. res_off_o is the padding offset when final and 0 when not final.
- R9: A final result returns the running total to zero, so the next request starts a new message.
- R10: msg_clear_i while idle zeroes the running total. When it comes in the same cycle as an accepted start, the total becomes that request's length alone.
- R11: A request shorter than eight bytes makes no reads and is reported not final, but its length still joins the running total.
- R12: Read data arrives on rd_data_i one cycle after rd_en_o, and every address issued is below the current request length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_clear_i | input | 1 | Restart the running total (idle only) |
| req_start_i | input | 1 | Start strobe for one request |
| req_len_i | input | LEN_W | Request length in bytes |
| busy_o | output | 1 | A request is in progress |
| rd_en_o | output | 1 | Byte read request |
| rd_addr_o | output | LEN_W | Byte address within the request buffer |
| rd_data_i | input | 8 | Read data, one cycle after rd_en_o |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_final_o | output | 1 | Request holds the closing padding |
| res_off_o | output | LEN_W | Padding start offset (0 when not final) |

## Verification
The bench builds buffers whose trailers carry chosen bit counts. It checks that a message split over two requests resolves only on the second. A design that summed lengths after the check, or read the trailer little-endian, would report the wrong offset or miss the final request. The boundary cases target a padding size of zero, one that equals the length (offset zero), and one larger than the length. A design with an off-by-one in the offset window would read outside the buffer or accept a bogus marker. Further cases cover a marker mismatch, a bit count that is not a multiple of eight, a too-short request whose length must still be counted, and clears alone and alongside a start. Each of these would expose a total that is not reset or not accumulated.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

  // number of trailer bytes carrying the big-endian bit count
  localparam int TRAIL_BYTES = 8;
  // marker byte opening the padding
  localparam logic [7:0] PAD_MARK = 8'h80;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TRAIL,
    ST_TLAST,
    ST_EVAL,
    ST_MARK
  } pdt_state_e;

endpackage

// File: rtl/pdt_accum.sv
module pdt_accum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         add_en,
  input  logic [W-1:0] add_len,
  input  logic         clr_en,
  input  logic         zero_en,
  output logic [W-1:0] total_o
);
  logic [W-1:0] base;

  assign base = clr_en ? '0 : total_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       total_o <= '0;
    else if (zero_en) total_o <= '0;
    else if (add_en)  total_o <= base + add_len;
    else if (clr_en)  total_o <= '0;
  end
endmodule

// File: rtl/pdt_trailer.sv
module pdt_trailer #(
  parameter int NB = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic [7:0]      byte_i,
  output logic [8*NB-1:0] trailer_o
);
  // bytes arrive most significant first, so shift toward the top
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      trailer_o <= '0;
    else if (cap_en) trailer_o <= {trailer_o[8*NB-9:0], byte_i};
  end
endmodule

// File: rtl/pdt_locate.sv
module pdt_locate #(
  parameter int LEN_W = 32
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] total_i,
  input  logic [63:0]      trailer_i,
  output logic             ok_o,
  output logic [LEN_W-1:0] off_o
);
  // bit count -> byte count, remainder dropped
  function automatic logic [63:0] claim_bytes(input logic [63:0] bits);
    return bits >> 3;
  endfunction

  // padding size; valid only when claim <= total
  function automatic logic [LEN_W-1:0] pad_size(input logic [LEN_W-1:0] tot,
                                                input logic [63:0] claim);
    return tot - claim[LEN_W-1:0];
  endfunction

  logic [63:0]      claim;
  logic             claim_fits;
  logic [LEN_W-1:0] pad;
  logic             pad_in_buf;

  assign claim      = claim_bytes(trailer_i);
  assign claim_fits = claim <= 64'(total_i);
  assign pad        = pad_size(total_i, claim);
  assign pad_in_buf = (pad != '0) && (pad <= len_i);
  assign ok_o       = claim_fits && pad_in_buf;
  assign off_o      = len_i - pad;
endmodule

// File: rtl/pad_trailer_detect.sv
module pad_trailer_detect #(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_clear_i,
  input  logic             req_start_i,
  input  logic [LEN_W-1:0] req_len_i,
  output logic             busy_o,
  output logic             rd_en_o,
  output logic [LEN_W-1:0] rd_addr_o,
  input  logic [7:0]       rd_data_i,
  output logic             res_valid_o,
  output logic             res_final_o,
  output logic [LEN_W-1:0] res_off_o
);
  import pdt_pkg::*;

  localparam int NB    = TRAIL_BYTES;
  localparam int IDX_W = $clog2(NB);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NB - 1);
  localparam logic [LEN_W-1:0] NB_LEN   = LEN_W'(NB);

  pdt_state_e       st_q;
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] len_q;
  logic             short_q;
  logic             trail_pend_q;
  logic [LEN_W-1:0] off_q;
  logic             res_valid_q;
  logic             res_final_q;
  logic [LEN_W-1:0] res_off_q;

  // named internal events
  logic             start_acc;
  logic             clr_acc;
  logic             mark_hit;
  logic             final_ev;
  logic [LEN_W-1:0] total;
  logic [8*NB-1:0]  trailer;
  logic             loc_ok;
  logic [LEN_W-1:0] loc_off;

  assign start_acc = (st_q == ST_IDLE) && req_start_i;
  assign clr_acc   = (st_q == ST_IDLE) && msg_clear_i;
  assign mark_hit  = (st_q == ST_MARK) && (rd_data_i == PAD_MARK);
  assign final_ev  = mark_hit;

  pdt_accum #(.W(LEN_W)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .add_en  (start_acc),
    .add_len (req_len_i),
    .clr_en  (clr_acc),
    .zero_en (final_ev),
    .total_o (total)
  );

  pdt_trailer #(.NB(NB)) u_trailer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (trail_pend_q),
    .byte_i    (rd_data_i),
    .trailer_o (trailer)
  );

  pdt_locate #(.LEN_W(LEN_W)) u_locate (
    .len_i     (len_q),
    .total_i   (total),
    .trailer_i (trailer),
    .ok_o      (loc_ok),
    .off_o     (loc_off)
  );

  always_comb begin
    rd_en_o   = 1'b0;
    rd_addr_o = '0;
    case (st_q)
      ST_TRAIL: begin
        rd_en_o   = 1'b1;
        rd_addr_o = len_q - NB_LEN + LEN_W'(idx_q);
      end
      ST_EVAL: begin
        if (!short_q && loc_ok) begin
          rd_en_o   = 1'b1;
          rd_addr_o = loc_off;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      idx_q        <= '0;
      len_q        <= '0;
      short_q      <= 1'b0;
      trail_pend_q <= 1'b0;
      off_q        <= '0;
      res_valid_q  <= 1'b0;
      res_final_q  <= 1'b0;
      res_off_q    <= '0;
    end else begin
      res_valid_q  <= 1'b0;
      trail_pend_q <= (st_q == ST_TRAIL);
      case (st_q)
        ST_IDLE: begin
          if (start_acc) begin
            len_q   <= req_len_i;
            short_q <= req_len_i < NB_LEN;
            idx_q   <= '0;
            st_q    <= (req_len_i < NB_LEN) ? ST_EVAL : ST_TRAIL;
          end
        end
        ST_TRAIL: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_LAST) st_q <= ST_TLAST;
        end
        ST_TLAST: st_q <= ST_EVAL;
        ST_EVAL: begin
          if (short_q || !loc_ok) begin
            res_valid_q <= 1'b1;
            res_final_q <= 1'b0;
            res_off_q   <= '0;
            st_q        <= ST_IDLE;
          end else begin
            off_q <= loc_off;
            st_q  <= ST_MARK;
          end
        end
        ST_MARK: begin
          res_valid_q <= 1'b1;
          res_final_q <= mark_hit;
          res_off_q   <= mark_hit ? off_q : '0;
          st_q        <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign res_valid_o = res_valid_q;
  assign res_final_o = res_valid_q && res_final_q;
  assign res_off_o   = res_off_q;

  // R2: an accepted start makes the block busy
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_start_i && !busy_o |=> busy_o);

  // R8: the result strobe never lasts two cycles
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o);

  // R6: a final offset lies inside the buffer
  assert_off_in_buf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_final_o |-> res_off_o < len_q);

  // R9: a final result leaves the running total at zero
  assert_final_total_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_final_o |-> total == '0);

  // R12: reads never leave the request buffer
  assert_rd_in_buf_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> rd_addr_o < len_q);

  // R11: a short request issues no read
  assert_short_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && short_q |-> !rd_en_o);
endmodule

// File: tb/pad_trailer_detect_tb.sv
module pad_trailer_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             msg_clear_i = 1'b0;
  logic             req_start_i = 1'b0;
  logic [LEN_W-1:0] req_len_i = '0;
  logic             busy_o;
  logic             rd_en_o;
  logic [LEN_W-1:0] rd_addr_o;
  logic [7:0]       rd_data_i;
  logic             res_valid_o;
  logic             res_final_o;
  logic [LEN_W-1:0] res_off_o;

  int total_checks = 0;
  int bad_checks = 0;
  int rd_cnt = 0;
  logic [7:0] mem [0:255];

  pad_trailer_detect #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .msg_clear_i(msg_clear_i),
    .req_start_i(req_start_i), .req_len_i(req_len_i), .busy_o(busy_o),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .res_valid_o(res_valid_o), .res_final_o(res_final_o), .res_off_o(res_off_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // buffer model: one-cycle read latency
  initial rd_data_i = 8'h00;
  always @(posedge clk) begin
    if (rd_en_o) begin
      rd_data_i <= mem[rd_addr_o[7:0]];
      rd_cnt    <= rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total_checks++;
    if (!ok) begin
      bad_checks++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_buf(input int len, input logic [63:0] bits, input int mpos, input logic [7:0] mval);
    for (int i = 0; i < 256; i++) mem[i] = 8'h5A;
    if (len >= 8)
      for (int k = 0; k < 8; k++) mem[len-8+k] = bits[63-8*k -: 8];
    if (mpos >= 0) mem[mpos] = mval;
  endtask

  task automatic run_req(input int len, input bit clr, input bit exp_fin,
                         input int exp_off, input int exp_rd, input string req);
    int n;
    @(negedge clk);
    rd_cnt = 0;
    req_start_i = 1'b1; req_len_i = LEN_W'(len); msg_clear_i = clr;
    @(negedge clk);
    req_start_i = 1'b0; msg_clear_i = 1'b0;
    chk(busy_o === 1'b1, {req, " busy R2"}, busy_o, 1);
    n = 0;
    while (res_valid_o !== 1'b1 && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(res_valid_o === 1'b1, {req, " valid R8"}, res_valid_o, 1);
    chk(res_final_o === exp_fin, {req, " final"}, res_final_o, exp_fin);
    chk(res_off_o === LEN_W'(exp_off), {req, " offset R8"}, res_off_o, exp_off);
    chk(rd_cnt == exp_rd, {req, " read count R12"}, rd_cnt, exp_rd);
    @(negedge clk);
    chk(res_valid_o === 1'b0, {req, " pulse R8"}, res_valid_o, 0);
  endtask

  task automatic clear_alone();
    @(negedge clk); msg_clear_i = 1'b1;
    @(negedge clk); msg_clear_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(busy_o === 1'b0, "R1 busy", busy_o, 0);
    chk(res_valid_o === 1'b0, "R1 valid", res_valid_o, 0);
    chk(rd_en_o === 1'b0, "R1 rd_en", rd_en_o, 0);
  endtask

  task automatic t_single();   // R3 R4 R7: 40-byte message in one 64-byte buffer
    set_buf(64, 64'd320, 40, 8'h80);
    run_req(64, 1'b0, 1'b1, 40, 9, "R7 single");
  endtask

  task automatic t_after_final();  // R9: total must restart at zero
    set_buf(32, 64'd128, 16, 8'h80);
    run_req(32, 1'b0, 1'b1, 16, 9, "R9 new message");
  endtask

  task automatic t_multi();    // R3 R5: first request claim too large, second closes
    set_buf(64, 64'hFFFF_FFFF_FFFF_FFF8, -1, 8'h00);
    run_req(64, 1'b0, 1'b0, 0, 8, "R5 huge claim");
    set_buf(64, 64'd800, 36, 8'h80);
    run_req(64, 1'b0, 1'b1, 36, 9, "R3 second request");
  endtask

  task automatic t_mark_bad(); // R7 then R10 clear alone
    set_buf(64, 64'd320, 40, 8'h7F);
    run_req(64, 1'b0, 1'b0, 0, 9, "R7 wrong marker");
    clear_alone();
    set_buf(64, 64'd320, 40, 8'h80);
    run_req(64, 1'b0, 1'b1, 40, 9, "R10 after clear");
  endtask

  task automatic t_clr_start(); // R10: clear with start
    set_buf(64, 64'hFFFF_FFFF_FFFF_FFF8, -1, 8'h00);
    run_req(64, 1'b0, 1'b0, 0, 8, "R10 prime");
    set_buf(64, 64'd320, 40, 8'h80);
    run_req(64, 1'b1, 1'b1, 40, 9, "R10 clear+start");
  endtask

  task automatic t_zero_pad(); // R6: claim equals total
    set_buf(64, 64'd512, -1, 8'h00);
    run_req(64, 1'b1, 1'b0, 0, 8, "R6 zero pad");
  endtask

  task automatic t_neg_off();  // R6: padding larger than buffer
    set_buf(64, 64'hFFFF_FFFF_FFFF_FFF8, -1, 8'h00);
    run_req(64, 1'b1, 1'b0, 0, 8, "R6 prime");
    set_buf(16, 64'd0, 0, 8'h80);
    run_req(16, 1'b0, 1'b0, 0, 8, "R6 negative offset");
  endtask

  task automatic t_off_zero(); // R6: padding equals length, offset 0
    set_buf(64, 64'hFFFF_FFFF_FFFF_FFF8, -1, 8'h00);
    run_req(64, 1'b1, 1'b0, 0, 8, "R6 prime2");
    set_buf(32, 64'd512, 0, 8'h80);
    run_req(32, 1'b0, 1'b1, 0, 9, "R6 offset zero");
  endtask

  task automatic t_trunc();    // R4: remainder bits dropped
    set_buf(64, 64'd327, 40, 8'h80);
    run_req(64, 1'b1, 1'b1, 40, 9, "R4 truncated count");
  endtask

  task automatic t_short();    // R11: short request still counted
    set_buf(4, 64'd0, -1, 8'h00);
    run_req(4, 1'b1, 1'b0, 0, 0, "R11 short");
    set_buf(60, 64'd320, 36, 8'h80);
    run_req(60, 1'b0, 1'b1, 36, 9, "R11 counted");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total_checks++;
    bad_checks++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_after_final();
    t_multi();
    t_mark_bad();
    t_clr_start();
    t_zero_pad();
    t_neg_off();
    t_off_zero();
    t_trunc();
    t_short();
    $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end
endmodule